// File: doc/BRIEF.md
# I2C Register-Access Target with Streaming Page Port

This block is an I2C target that sits at one fixed 7-bit bus address. It gives a bus controller byte-wide access to an internal space of 8-bit registers. A write transaction carries a register index in its first byte, and every byte after it is stored into the space. A read transaction returns bytes from wherever the index currently points. For ordinary registers the index moves forward by one after each byte, so a single transaction can cover a contiguous run of registers.

One index, the data port (default 0x70), is not a register. It is a window onto a separate page buffer of up to 256 bytes. Setting the index to the data port rewinds a page cursor to zero. Each byte written or read through the port then uses the next page location, while the index itself stays on the port. A whole page can therefore pass in one burst. The controller reads a register by writing a one-byte index transaction and then issuing a read transaction, either after a STOP or after a repeated START.

The bus lines are brought in through a two-flop synchroniser. START and STOP are recognised from SDA edges while SCL is high. The engine is a state machine with these states:
- `ST_IDLE`: ignores the bus.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_RX` / `ST_RX_ACK`: receive a byte and acknowledge it.
- `ST_TX` / `ST_TX_ACK`: send a byte and sample the controller's acknowledge.

Transitions:
- START from any state goes to `ST_ADDR`. STOP from any state goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on the eighth falling SCL edge if the address matches, and to `ST_IDLE` if it does not.
- `ST_ADDR_ACK` goes to `ST_TX` (read) or `ST_RX` (write) on the next falling edge.
- `ST_RX` and `ST_RX_ACK` alternate on byte and acknowledge boundaries. `ST_TX` and `ST_TX_ACK` do the same.
- `ST_TX_ACK` returns to `ST_IDLE` when the controller did not acknowledge.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges its own 7-bit address (default 0x4A, the bus byte being address in bits 7:1 and the read flag in bit 0, 1 = read) by pulling SDA low during the ninth clock.
- R2: Any other address is not acknowledged: SDA stays released for that transaction, and bytes that follow it change no register.
- R3: In a write transaction, the first byte after the address loads the register index.
- R4: Each later byte of a write transaction is stored at the index and acknowledged, and the index then increases by one for an ordinary register.
- R5: A read transaction returns the byte at the index, MSB first, and the index increases by one after each byte sent from an ordinary register.
- R6: Bytes written while the index equals the data port (0x70) go to the page buffer at successive locations starting from location 0 after the index was loaded. The index stays at 0x70, so a 256-byte burst leaves register 0x71 untouched.
- R7: Bytes read while the index equals the data port come from successive page-buffer locations starting from location 0 after the index was loaded.
- R8: A STOP or a repeated START ends a burst and leaves the index where the burst left it, so the next read continues from there.
- R9: When the controller does not acknowledge a read byte, the target releases SDA and stays silent until the next START.
- R10: After reset every register reads 0 and SDA is released.
- R11: When an ordinary index steps up into the data port (0x6F to 0x70), the following bytes stream through the page buffer from location 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | High to pull SDA low (open drain), low to release |

## Verification
The assertions assume a well-behaved controller. It changes SDA only while SCL is low, except when it signals START or STOP. It never attempts a START or STOP while the target holds SDA low, and it holds each SCL phase for several system clocks so that the synchroniser sees every edge. The bench drives the bus from tasks that place SDA changes a fixed number of clocks after each SCL fall, and it ends every read with a not-acknowledge before the STOP. Under these conditions the target's output may move only while the synchronised SCL is low.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_p, sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h4A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_s,
    input  logic [7:0] rd_data,
    output logic       set_ptr,
    output logic       wr_en,
    output logic       rd_adv,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output tgt_state_e state
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    tgt_state_e state_q, state_d;
    logic [7:0] shreg;
    logic [3:0] bit_cnt;
    logic       rw_q, first_q, nack_q;
    logic       byte_end;

    assign byte_end = scl_fall && (bit_cnt == BYTE_BITS);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 state_d = (shreg[7:1] == TARGET_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_TX : ST_RX;
                ST_RX:       if (byte_end) state_d = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_d = ST_RX;
                ST_TX:       if (byte_end) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_d = nack_q ? ST_IDLE : ST_TX;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: shift register, bit counter, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            rw_q    <= 1'b0;
            first_q <= 1'b0;
            nack_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_end) begin
                        bit_cnt <= '0;
                        if (state_q == ST_ADDR) begin
                            rw_q    <= shreg[0];
                            first_q <= 1'b1;
                        end else begin
                            first_q <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_q) shreg <= rd_data;
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (bit_cnt == BYTE_BITS) bit_cnt <= '0;
                        else                      shreg <= {shreg[6:0], 1'b0};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) nack_q <= sda_s;
                    else if (scl_fall && !nack_q) shreg <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        set_ptr = 1'b0;
        wr_en   = 1'b0;
        rd_adv  = 1'b0;
        sda_oe  = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK: begin
                sda_oe = 1'b1;
                rd_adv = scl_fall && rw_q && !start_det && !stop_det;
            end
            ST_RX: begin
                set_ptr = byte_end && first_q && !start_det && !stop_det;
                wr_en   = byte_end && !first_q && !start_det && !stop_det;
            end
            ST_RX_ACK:  sda_oe = 1'b1;
            ST_TX:      sda_oe = ~shreg[7];
            ST_TX_ACK:  rd_adv = scl_fall && !nack_q && !start_det && !stop_det;
            default: ;
        endcase
    end

    assign wr_data = shreg;
    assign state   = state_q;
endmodule

// File: rtl/i2c_regport_store.sv
module i2c_regport_store #(
    parameter int            PTR_W      = 8,
    parameter int            DATA_W     = 8,
    parameter int            PAGE_DEPTH = 256,
    parameter logic [PTR_W-1:0] DATA_PORT = 8'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ptr,
    input  logic              wr_en,
    input  logic              rd_adv,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr
);
    localparam int REG_DEPTH = 1 << PTR_W;
    localparam int CUR_W     = (PAGE_DEPTH > 1) ? $clog2(PAGE_DEPTH) : 1;
    localparam logic [CUR_W-1:0] CUR_LAST = CUR_W'(PAGE_DEPTH - 1);

    logic [DATA_W-1:0] regs [REG_DEPTH];
    logic [DATA_W-1:0] page [PAGE_DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [CUR_W-1:0]  cur_q, cur_nxt;
    logic              at_port;

    assign at_port = (ptr_q == DATA_PORT);
    assign cur_nxt = (cur_q == CUR_LAST) ? '0 : cur_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cur_q <= '0;
            for (int i = 0; i < REG_DEPTH; i++)  regs[i] <= '0;
            for (int i = 0; i < PAGE_DEPTH; i++) page[i] <= '0;
        end else if (set_ptr) begin
            ptr_q <= wr_data[PTR_W-1:0];
            cur_q <= '0;
        end else if (wr_en) begin
            if (at_port) begin
                page[cur_q] <= wr_data;
                cur_q       <= cur_nxt;
            end else begin
                regs[ptr_q] <= wr_data;
                ptr_q       <= ptr_q + 1'b1;
            end
        end else if (rd_adv) begin
            if (at_port) cur_q <= cur_nxt;
            else         ptr_q <= ptr_q + 1'b1;
        end
    end

    assign rd_data = at_port ? page[cur_q] : regs[ptr_q];
    assign ptr     = ptr_q;
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h4A,
    parameter int          PTR_W       = 8,
    parameter int          PAGE_DEPTH  = 256,
    parameter logic [7:0]  DATA_PORT   = 8'h70,
    parameter int          SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int DATA_W = 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic set_ptr, wr_en, rd_adv;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic [PTR_W-1:0]  ptr_q;
    tgt_state_e        state_q;

    i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_regport_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .rd_data(rd_data), .set_ptr(set_ptr), .wr_en(wr_en), .rd_adv(rd_adv),
        .wr_data(wr_data), .sda_oe(sda_oe), .state(state_q)
    );

    i2c_regport_store #(
        .PTR_W(PTR_W), .DATA_W(DATA_W), .PAGE_DEPTH(PAGE_DEPTH),
        .DATA_PORT(DATA_PORT[PTR_W-1:0])
    ) u_store (
        .clk(clk), .rst_n(rst_n), .set_ptr(set_ptr), .wr_en(wr_en),
        .rd_adv(rd_adv), .wr_data(wr_data), .rd_data(rd_data), .ptr(ptr_q)
    );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_regport_pkg::*;
#(
    parameter int         PTR_W     = 8,
    parameter logic [7:0] DATA_PORT = 8'h70
) (
    input logic             clk,
    input logic             rst_n,
    input tgt_state_e       state,
    input logic             sda_oe,
    input logic             scl_s,
    input logic             set_ptr,
    input logic             wr_en,
    input logic             rd_adv,
    input logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] PORT_IDX = DATA_PORT[PTR_W-1:0];

    // R1: the target only moves SDA while SCL is low
    a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R9: a silent target never pulls SDA
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R3: index load, store and read advance never coincide
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_ptr, wr_en, rd_adv}));

    // R4: a stored ordinary byte moves the index by one
    a_r4_ptr_step_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr != PORT_IDX) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R5: a sent ordinary byte moves the index by one
    a_r5_ptr_step_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && ptr != PORT_IDX) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R6 / R11: the index stays on the data port until reloaded
    a_r6_port_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PORT_IDX && !set_ptr) |=> (ptr == PORT_IDX));
endmodule

bind i2c_regport i2c_regport_chk #(.PTR_W(PTR_W), .DATA_PORT(DATA_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .sda_oe(sda_oe), .scl_s(scl_s),
    .set_ptr(set_ptr), .wr_en(wr_en), .rd_adv(rd_adv), .ptr(ptr_q)
);

// File: tb/i2c_regport_test.sv
module i2c_regport_test;
    localparam logic [6:0] OWN = 7'h4A;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #5 clk = ~clk;

    i2c_regport uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] tx_buf [300];
    logic [7:0] rx_buf [300];
    logic [7:0] exp_reg [256];
    logic [7:0] exp_page [256];

    function automatic logic [7:0] fr(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] fp(int i);
        return 8'((i * 13) ^ 8'hA5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_drv = b; wq();
        scl = 1'b1; wq();
        r = sda_line; wq();
        scl = 1'b0; wq();
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1; wq();
        scl = 1'b1; wq();
        sda_drv = 1'b0; wq();
        scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0; wq();
        scl = 1'b1; wq();
        sda_drv = 1'b1; wq(); wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
        bit_xfer(1'b1, r);
        acked = (r == 1'b0);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            b[i] = r;
        end
        bit_xfer(nack, r);
    endtask

    // write to own address: index then n-1 data bytes from tx_buf
    task automatic wr_txn(input int n, input bit do_stop);
        logic ack;
        i2c_start();
        send_byte({OWN, 1'b0}, ack);
        check(ack, "R1 write address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(tx_buf[k], ack);
            check(ack, (k == 0) ? "R3 index ack" : "R4 data ack", ack, 1);
        end
        if (do_stop) i2c_stop();
    endtask

    task automatic rd_txn(input int n);
        logic ack;
        i2c_start();
        send_byte({OWN, 1'b1}, ack);
        check(ack, "R1 read address ack", ack, 1);
        for (int k = 0; k < n; k++) recv_byte(k == n - 1, rx_buf[k]);
        @(negedge clk);
        check(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic set_index(input logic [7:0] idx);
        tx_buf[0] = idx;
        wr_txn(1, 1'b1);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int i = 0; i < 256; i++) begin
            exp_reg[i] = 8'h00;
            exp_page[i] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state
        check(sda_oe == 1'b0, "R10 sda released", sda_oe, 0);
        set_index(8'h00);
        rd_txn(4);
        for (int k = 0; k < 4; k++)
            check(rx_buf[k] == 8'h00, "R10 reset register", rx_buf[k], 0);

        // R3 R4: burst write of 64 ordinary registers
        tx_buf[0] = 8'h00;
        for (int k = 0; k < 64; k++) begin
            tx_buf[k + 1] = fr(k);
            exp_reg[k] = fr(k);
        end
        wr_txn(65, 1'b1);
        // R5: burst read back
        set_index(8'h00);
        rd_txn(64);
        for (int k = 0; k < 64; k++)
            check(rx_buf[k] == exp_reg[k], "R5 burst read", rx_buf[k], exp_reg[k]);

        // R2: every foreign address, both directions, is not acknowledged
        for (int a = 0; a < 128; a++) begin
            if (a != int'(OWN)) begin
                logic [6:0] a7 = 7'(a);
                i2c_start();
                send_byte({a7, a7[0]}, ack);
                check(!ack, "R2 foreign address nack", ack, 0);
                i2c_stop();
            end
        end
        // R2: bytes after a foreign address are dropped
        i2c_start();
        send_byte({7'h4B, 1'b0}, ack);
        send_byte(8'h05, ack);
        check(!ack, "R2 foreign data nack", ack, 0);
        send_byte(8'hEE, ack);
        i2c_stop();
        set_index(8'h05);
        rd_txn(1);
        check(rx_buf[0] == exp_reg[5], "R2 register untouched", rx_buf[0], exp_reg[5]);

        // R8: repeated start keeps the index; so does STOP
        tx_buf[0] = 8'h10;
        tx_buf[1] = 8'hA5;
        exp_reg[16] = 8'hA5;
        wr_txn(2, 1'b0);
        rd_txn(1);
        check(rx_buf[0] == exp_reg[17], "R8 read after repeated start", rx_buf[0], exp_reg[17]);
        rd_txn(1);
        check(rx_buf[0] == exp_reg[18], "R8 read continues after stop", rx_buf[0], exp_reg[18]);
        set_index(8'h10);
        rd_txn(1);
        check(rx_buf[0] == 8'hA5, "R4 single write stored", rx_buf[0], 8'hA5);

        // R6: full page through the data port
        tx_buf[0] = 8'h70;
        for (int k = 0; k < 256; k++) begin
            tx_buf[k + 1] = fp(k);
            exp_page[k] = fp(k);
        end
        wr_txn(257, 1'b1);
        // R7: full page read back
        set_index(8'h70);
        rd_txn(256);
        for (int k = 0; k < 256; k++)
            check(rx_buf[k] == exp_page[k], "R7 page read", rx_buf[k], exp_page[k]);
        set_index(8'h71);
        rd_txn(1);
        check(rx_buf[0] == 8'h00, "R6 index stayed on port", rx_buf[0], 0);

        // R11: stepping from 0x6F into the port
        tx_buf[0] = 8'h6E;
        tx_buf[1] = 8'h11;
        tx_buf[2] = 8'h22;
        tx_buf[3] = 8'h33;
        tx_buf[4] = 8'h44;
        wr_txn(5, 1'b1);
        exp_reg[8'h6E] = 8'h11;
        exp_reg[8'h6F] = 8'h22;
        exp_page[0] = 8'h33;
        exp_page[1] = 8'h44;
        set_index(8'h6E);
        rd_txn(5);
        check(rx_buf[0] == exp_reg[8'h6E], "R11 reg 6E", rx_buf[0], exp_reg[8'h6E]);
        check(rx_buf[1] == exp_reg[8'h6F], "R11 reg 6F", rx_buf[1], exp_reg[8'h6F]);
        for (int k = 0; k < 3; k++)
            check(rx_buf[k + 2] == exp_page[k], "R11 page stream", rx_buf[k + 2], exp_page[k]);

        done = 1'b1;
        report();
        $finish;
    end
endmodule